// File: doc/BRIEF.md
# Link Equalization Phase Sequencer

This block steps one end of a multi-lane serial link through the four transmitter equalization phases (0 to 3) that an 8 GT/s link must pass before it returns to receiver-lock recovery. It watches the 2-bit equalization-control code carried in the training sets received on each lane. It decides when every active lane agrees on the code it expects, and it chooses the equalization-control code for its own outgoing training sets. It also reports the current phase.

The sequencer serves either end of the link. In the upstream role it starts phase 0 while the link still runs at a lower rate. It leaves phase 0 once the receivers lock at the new rate. In the downstream role it starts phase 0 after the speed change and pulses a strobe so that the received starting presets are applied to its transmitter. A received code counts only after it has repeated on a programmable number of consecutive training sets on a locked lane. A per-phase timeout returns the sequencer to idle with an error pulse. A skip control shortens the two optional tuning phases so that each lasts one qualifying exchange, but the sequencer still passes through them.

Top module: `eq_phase_seq`

## Requirements
- R1: After reset the sequencer is idle: busy low, phase 0, transmitted code 2'b00, and the preset, done and error pulses low.
- R2: A start pulse while idle enters phase 0 and latches the role. In the downstream role (role_up_i = 0) preset_apply_o pulses for one cycle at entry. The upstream role gives no such pulse. A start pulse while busy is ignored.
- R3: On a lane, a code is detected once it has been received on match_lim_i consecutive valid training sets while the lane is locked (a limit of 0 acts as 1). A valid set carrying another code, or a cycle with the lane's lock flag low, restarts the run. Cycles without a valid set leave the run unchanged. All runs restart on every phase change.
- R4: A phase advances on a received code only when every lane enabled in lane_en_i has detected it. Disabled lanes are ignored. With no lane enabled, nothing advances.
- R5: Upstream phase 0 advances to phase 1 as soon as every enabled lane reports lock.
- R6: Upstream role: phase 1 waits for code 2'b01, phase 2 waits for code 2'b11, and phase 3 waits for code 2'b11 plus the tuning condition of R8 before it completes.
- R7: Downstream role: phase 0 waits for code 2'b01, phase 1 waits for 2'b10, phase 2 waits for 2'b10 plus the tuning condition of R8, and phase 3 waits for 2'b00 before it completes.
- R8: In the phase where this end does the tuning (phase 3 upstream, phase 2 downstream), the phase advances only if tune_done_i or skip_tune_i is high in the cycle that the code is detected on all lanes. With skip_tune_i high, the phase advances at that detection.
- R9: Completing phase 3 returns to idle, with eq_done_o high for exactly one cycle and the transmitted code back at 2'b00.
- R10: If a phase has lasted tmo_lim_i cycles beyond its first cycle without advancing, the sequencer returns to idle with eq_err_o high for one cycle. Advancing takes priority over the timeout.
- R11: While busy, the transmitted code equals the phase number (2'b00 to 2'b11). The phase never decreases or skips a value, so every completed run passes through all four phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eq_start_i | input | 1 | Begin equalization (upstream: entering at low rate; downstream: after speed change) |
| role_up_i | input | 1 | 1 = upstream role, 0 = downstream role; latched at start |
| skip_tune_i | input | 1 | Shorten phases 2 and 3 to one qualifying exchange |
| tune_done_i | input | 1 | Local coefficient tuning has finished |
| lane_en_i | input | LANES | Active lane mask |
| ts_vld_i | input | LANES | Per-lane strobe: a training set was received this cycle |
| ts_ec_i | input | 2*LANES | Per-lane received code, lane n in bits [2n+1:2n] |
| ts_lock_i | input | LANES | Per-lane decode-lock flag |
| match_lim_i | input | MATCH_W | Consecutive matching sets needed for detection |
| tmo_lim_i | input | TMO_W | Per-phase timeout in cycles |
| eq_phase_o | output | 2 | Current phase (0 while idle) |
| eq_busy_o | output | 1 | Sequence in progress |
| tx_ec_o | output | 2 | Code for outgoing training sets |
| preset_apply_o | output | 1 | One-cycle strobe: apply received starting presets |
| eq_done_o | output | 1 | One-cycle pulse: hand over to receiver-lock recovery |
| eq_err_o | output | 1 | One-cycle pulse: timeout, back to idle |

## Verification
A wrong phase register shows up at once on eq_phase_o and tx_ec_o, one clock after the bad transition. A lane run counter that is off by one moves the phase advance one cycle early or late, so the per-clock reference comparison catches it on the first affected edge. A bad phase timer shows up as an error pulse in the wrong cycle, or as a missing one. A wrong latched role or a wrong tuning gate shows up within a single phase as a phase that holds or advances against the expected code.

// File: rtl/eqs_pkg.sv
package eqs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PH0  = 3'd1,
        ST_PH1  = 3'd2,
        ST_PH2  = 3'd3,
        ST_PH3  = 3'd4
    } eqs_state_e;

    typedef struct packed {
        eqs_state_e st;
        logic       up;
        logic       done;
        logic       err;
        logic       pre;
    } eqs_regs_t;

    // Code each phase waits for, per role
    function automatic logic [1:0] wait_code(input logic up, input eqs_state_e st);
        logic [1:0] c;
        c = 2'b00;
        if (up) begin
            case (st)
                ST_PH1:  c = 2'b01;
                ST_PH2:  c = 2'b11;
                ST_PH3:  c = 2'b11;
                default: c = 2'b00;
            endcase
        end else begin
            case (st)
                ST_PH0:  c = 2'b01;
                ST_PH1:  c = 2'b10;
                ST_PH2:  c = 2'b10;
                default: c = 2'b00;
            endcase
        end
        return c;
    endfunction

    // Phase in which this end tunes its partner
    function automatic logic own_tune(input logic up, input eqs_state_e st);
        return up ? (st == ST_PH3) : (st == ST_PH2);
    endfunction

endpackage

// File: rtl/eqs_lane_match.sv
module eqs_lane_match #(
    parameter int MW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          vld_i,
    input  logic [1:0]    ec_i,
    input  logic          lock_i,
    input  logic [1:0]    want_i,
    input  logic [MW-1:0] lim_i,
    output logic          qual_o
);
    localparam logic [MW-1:0] RUN_MAX = {MW{1'b1}};
    localparam logic [MW-1:0] ONE     = {{(MW-1){1'b0}}, 1'b1};

    logic [MW-1:0] run_d, run_q;
    logic [MW-1:0] lim_eff;

    always_comb begin
        run_d = run_q;
        if (clr_i || !lock_i) begin
            run_d = '0;
        end else if (vld_i) begin
            if (ec_i == want_i) begin
                run_d = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
            end else begin
                run_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    assign lim_eff = (lim_i == '0) ? ONE : lim_i;
    assign qual_o  = (run_q >= lim_eff);

    // R3: a mismatching valid set on a locked lane restarts the run
    a_r3_mismatch_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && lock_i && (ec_i != want_i)) |=> !qual_o);

    // R3: loss of lock restarts the run
    a_r3_lock_loss_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_i || clr_i) |=> !qual_o);

endmodule

// File: rtl/eqs_phase_timer.sv
module eqs_phase_timer #(
    parameter int TW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic [TW-1:0] lim_i,
    output logic          expire_o
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)               cnt_d = '0;
        else if (cnt_q != lim_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire_o = (cnt_q == lim_i);

    // R10: a freshly restarted phase cannot expire at once unless the limit is zero or moved
    a_r10_fresh_not_expired: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (lim_i != '0)) |=> (!expire_o || !$stable(lim_i)));

endmodule

// File: rtl/eq_phase_seq.sv
module eq_phase_seq
    import eqs_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int MATCH_W = 3,
    parameter int TMO_W   = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 eq_start_i,
    input  logic                 role_up_i,
    input  logic                 skip_tune_i,
    input  logic                 tune_done_i,
    input  logic [LANES-1:0]     lane_en_i,
    input  logic [LANES-1:0]     ts_vld_i,
    input  logic [2*LANES-1:0]   ts_ec_i,
    input  logic [LANES-1:0]     ts_lock_i,
    input  logic [MATCH_W-1:0]   match_lim_i,
    input  logic [TMO_W-1:0]     tmo_lim_i,
    output logic [1:0]           eq_phase_o,
    output logic                 eq_busy_o,
    output logic [1:0]           tx_ec_o,
    output logic                 preset_apply_o,
    output logic                 eq_done_o,
    output logic                 eq_err_o
);
    localparam eqs_regs_t REGS_RST = '{st: ST_IDLE, up: 1'b0, done: 1'b0, err: 1'b0, pre: 1'b0};

    eqs_regs_t        r_d, r_q;
    logic [LANES-1:0] lane_qual;
    logic [1:0]       want;
    logic             all_qual;
    logic             all_lock;
    logic             tune_ok;
    logic             advance;
    logic             expire;
    logic             restart;

    assign want = wait_code(r_q.up, r_q.st);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        eqs_lane_match #(.MW(MATCH_W)) u_match (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr_i  (restart),
            .vld_i  (ts_vld_i[g]),
            .ec_i   (ts_ec_i[2*g +: 2]),
            .lock_i (ts_lock_i[g]),
            .want_i (want),
            .lim_i  (match_lim_i),
            .qual_o (lane_qual[g])
        );
    end

    eqs_phase_timer #(.TW(TMO_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (restart),
        .lim_i    (tmo_lim_i),
        .expire_o (expire)
    );

    assign all_qual = (|lane_en_i) && (&(lane_qual | ~lane_en_i));
    assign all_lock = (|lane_en_i) && (&(ts_lock_i | ~lane_en_i));
    assign tune_ok  = skip_tune_i || tune_done_i || !own_tune(r_q.up, r_q.st);

    always_comb begin
        advance = 1'b0;
        case (r_q.st)
            ST_PH0:  advance = r_q.up ? all_lock : all_qual;
            ST_PH1:  advance = all_qual;
            ST_PH2,
            ST_PH3:  advance = all_qual && tune_ok;
            default: advance = 1'b0;
        endcase
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        r_d.pre  = 1'b0;
        if (r_q.st == ST_IDLE) begin
            if (eq_start_i) begin
                r_d.st  = ST_PH0;
                r_d.up  = role_up_i;
                r_d.pre = !role_up_i;
            end
        end else if (advance) begin
            case (r_q.st)
                ST_PH0:  r_d.st = ST_PH1;
                ST_PH1:  r_d.st = ST_PH2;
                ST_PH2:  r_d.st = ST_PH3;
                default: begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            endcase
        end else if (expire) begin
            r_d.st  = ST_IDLE;
            r_d.err = 1'b1;
        end
        restart = (r_d.st != r_q.st) || (r_q.st == ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    always_comb begin
        case (r_q.st)
            ST_PH1:  eq_phase_o = 2'd1;
            ST_PH2:  eq_phase_o = 2'd2;
            ST_PH3:  eq_phase_o = 2'd3;
            default: eq_phase_o = 2'd0;
        endcase
    end

    assign eq_busy_o      = (r_q.st != ST_IDLE);
    assign tx_ec_o        = eq_phase_o;
    assign preset_apply_o = r_q.pre;
    assign eq_done_o      = r_q.done;
    assign eq_err_o       = r_q.err;

    // R9: completion only follows phase 3 and leaves the block idle
    a_r9_done_after_ph3: assert property (@(posedge clk) disable iff (!rst_n)
        eq_done_o |-> ($past(eq_busy_o) && ($past(eq_phase_o) == 2'd3) && !eq_busy_o));

    // R10: an error pulse leaves the block idle and never coincides with completion
    a_r10_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        eq_err_o |-> (!eq_busy_o && !eq_done_o && $past(eq_busy_o)));

    // R11: phase holds or steps by one while busy
    a_r11_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (eq_busy_o && $past(eq_busy_o)) |->
        ((eq_phase_o == $past(eq_phase_o)) || (eq_phase_o == $past(eq_phase_o) + 2'd1)));

    // R2: preset strobe only on entry into phase 0 from idle
    a_r2_preset_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        preset_apply_o |-> (eq_busy_o && (eq_phase_o == 2'd0) && !$past(eq_busy_o)));

    // R4: with no enabled lane the run cannot complete
    a_r4_no_lane_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        (eq_busy_o && (lane_en_i == '0)) |=> !eq_done_o);

    // R8: without tuning permission the tuning phase does not advance
    a_r8_tune_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (eq_busy_o && !skip_tune_i && !tune_done_i && own_tune(r_q.up, r_q.st)) |=>
        (!eq_done_o && (!eq_busy_o || (eq_phase_o == $past(eq_phase_o)))));

endmodule

// File: tb/sim_eq_phase_seq.sv
`timescale 1ns/1ps
module sim_eq_phase_seq;
    localparam int L  = 4;
    localparam int MW = 3;
    localparam int TW = 10;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic            rst_n;
    logic            eq_start, role_up, skip_tune, tune_done;
    logic [L-1:0]    lane_en, ts_vld, ts_lock;
    logic [2*L-1:0]  ts_ec;
    logic [MW-1:0]   match_lim;
    logic [TW-1:0]   tmo_lim;
    logic [1:0]      phase, tx_ec;
    logic            busy, pre, done, err;

    eq_phase_seq #(.LANES(L), .MATCH_W(MW), .TMO_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .eq_start_i(eq_start), .role_up_i(role_up),
        .skip_tune_i(skip_tune), .tune_done_i(tune_done), .lane_en_i(lane_en),
        .ts_vld_i(ts_vld), .ts_ec_i(ts_ec), .ts_lock_i(ts_lock),
        .match_lim_i(match_lim), .tmo_lim_i(tmo_lim), .eq_phase_o(phase),
        .eq_busy_o(busy), .tx_ec_o(tx_ec), .preset_apply_o(pre),
        .eq_done_o(done), .eq_err_o(err)
    );

    int checks = 0;
    int errors = 0;
    bit cmp_en = 0;
    bit junk3  = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int m_state;        // -1 idle, else phase number
    bit m_up, m_done, m_err, m_pre;
    int m_run[L];
    int m_tmo;

    function automatic int want_of(bit up, int ph);
        if (up) return (ph == 1) ? 1 : (ph >= 2) ? 3 : 0;
        return (ph == 0) ? 1 : (ph == 1 || ph == 2) ? 2 : 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = -1; m_up = 0; m_done = 0; m_err = 0; m_pre = 0; m_tmo = 0;
            foreach (m_run[i]) m_run[i] = 0;
        end else begin
            int nxt, lim, w;
            bit any, qual, lockall, go, tuner;
            lim = (match_lim == 0) ? 1 : int'(match_lim);
            w = want_of(m_up, m_state);
            any = (lane_en != 0);
            qual = any; lockall = any;
            for (int i = 0; i < L; i++) begin
                if (lane_en[i] && m_run[i] < lim) qual = 0;
                if (lane_en[i] && !ts_lock[i]) lockall = 0;
            end
            tuner = m_up ? (m_state == 3) : (m_state == 2);
            nxt = m_state; m_done = 0; m_err = 0; m_pre = 0;
            if (m_state < 0) begin
                if (eq_start) begin nxt = 0; m_up = role_up; m_pre = !role_up; end
            end else begin
                if (m_state == 0 && m_up) go = lockall;
                else go = qual && (!tuner || skip_tune || tune_done);
                if (go) begin
                    if (m_state == 3) begin nxt = -1; m_done = 1; end
                    else nxt = m_state + 1;
                end else if (m_tmo == int'(tmo_lim)) begin
                    nxt = -1; m_err = 1;
                end
            end
            for (int i = 0; i < L; i++) begin
                if (nxt != m_state || m_state < 0 || !ts_lock[i]) m_run[i] = 0;
                else if (ts_vld[i]) begin
                    if (int'(ts_ec[2*i +: 2]) == w) m_run[i] = (m_run[i] < 7) ? m_run[i] + 1 : 7;
                    else m_run[i] = 0;
                end
            end
            if (nxt != m_state || m_state < 0) m_tmo = 0;
            else if (m_tmo != int'(tmo_lim)) m_tmo++;
            m_state = nxt;
        end
    end

    // ---------------- per-clock comparison and monitors ----------------
    int done_cnt = 0, err_cnt = 0, pre_cnt = 0;
    int seen = 0;
    always @(negedge clk) begin
        if (cmp_en) begin
            int eph;
            eph = (m_state < 0) ? 0 : m_state;
            chk("R11 R6 R7 phase", phase, eph);
            chk("R11 tx code", tx_ec, eph);
            chk("R2 busy", busy, (m_state >= 0));
            chk("R2 preset", pre, m_pre);
            chk("R9 done", done, m_done);
            chk("R10 err", err, m_err);
            if (done) done_cnt++;
            if (err)  err_cnt++;
            if (pre)  pre_cnt++;
            if (busy) seen = seen | (1 << phase);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_start();
        eq_start = 1'b1;
        @(negedge clk);
        eq_start = 1'b0;
    endtask

    task automatic send(input logic [1:0] ec, input int n, input int bad_lane, input logic [1:0] bad_ec);
        for (int k = 0; k < n; k++) begin
            for (int i = 0; i < L; i++) begin
                if (i == bad_lane)           ts_ec[2*i +: 2] = bad_ec;
                else if (junk3 && i == 3)    ts_ec[2*i +: 2] = 2'b11;
                else                         ts_ec[2*i +: 2] = ec;
            end
            ts_vld = '1;
            @(negedge clk);
        end
        ts_vld = '0;
        ts_ec  = '0;
    endtask

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog expired (R9 completion not reached)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 0; eq_start = 0; role_up = 0; skip_tune = 0; tune_done = 0;
        lane_en = '1; ts_vld = '0; ts_ec = '0; ts_lock = '1;
        match_lim = 3'd2; tmo_lim = 10'd60;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cmp_en = 1;
        wait_cyc(1);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 phase", phase, 0);
        chk("R1 tx code", tx_ec, 0);
        chk("R1 pulses", {pre, done, err}, 0);

        // ---- downstream, full tuning ----
        pulse_start();
        wait_cyc(1);
        chk("R2 downstream preset strobe", pre_cnt, 1);
        send(2'b01, 3, -1, 2'b00);
        wait_cyc(1);
        chk("R7 downstream phase1", phase, 1);
        pulse_start();
        wait_cyc(1);
        chk("R2 start ignored while busy", pre_cnt, 1);
        chk("R2 start ignored phase", phase, 1);
        send(2'b10, 3, -1, 2'b00);
        send(2'b10, 3, -1, 2'b00);
        wait_cyc(3);
        chk("R8 tuning phase holds", phase, 2);
        tune_done = 1'b1;
        @(negedge clk);
        tune_done = 1'b0;
        wait_cyc(1);
        chk("R8 tuning release", phase, 3);
        send(2'b00, 3, -1, 2'b00);
        wait_cyc(2);
        chk("R9 done pulse count", done_cnt, 1);
        chk("R9 idle after done", busy, 0);
        chk("R9 tx code idle", tx_ec, 0);
        chk("R11 all phases visited", seen, 15);

        // ---- upstream with late lock ----
        role_up = 1'b1;
        ts_lock = 4'b1011;
        pulse_start();
        wait_cyc(4);
        chk("R5 upstream waits for lock", phase, 0);
        chk("R5 upstream busy", busy, 1);
        ts_lock = '1;
        wait_cyc(2);
        chk("R5 upstream phase1", phase, 1);
        send(2'b01, 3, -1, 2'b00);
        wait_cyc(1);
        chk("R6 upstream phase2", phase, 2);
        send(2'b11, 3, -1, 2'b00);
        wait_cyc(1);
        chk("R6 upstream phase3", phase, 3);
        tune_done = 1'b1;
        send(2'b11, 3, -1, 2'b00);
        tune_done = 1'b0;
        wait_cyc(2);
        chk("R6 upstream completes", done_cnt, 2);
        chk("R2 no preset in upstream role", pre_cnt, 1);

        // ---- downstream, skip, limit 3, lane 3 disabled and noisy ----
        role_up = 1'b0; skip_tune = 1'b1; match_lim = 3'd3;
        lane_en = 4'b0111; junk3 = 1;
        pulse_start();
        send(2'b01, 2, -1, 2'b00);
        send(2'b01, 1, 1, 2'b00);
        send(2'b01, 2, -1, 2'b00);
        wait_cyc(1);
        chk("R3 corrupted set restarts run", phase, 0);
        send(2'b01, 2, -1, 2'b00);
        wait_cyc(1);
        chk("R3 run completes", phase, 1);
        send(2'b10, 2, -1, 2'b00);
        ts_lock = 4'b1110;
        @(negedge clk);
        ts_lock = '1;
        send(2'b10, 2, -1, 2'b00);
        wait_cyc(1);
        chk("R3 lock loss restarts run", phase, 1);
        send(2'b10, 2, -1, 2'b00);
        wait_cyc(1);
        chk("R4 disabled lane ignored", phase, 2);
        send(2'b10, 4, -1, 2'b00);
        wait_cyc(1);
        chk("R8 skip advances without tuning", phase, 3);
        send(2'b00, 4, -1, 2'b00);
        wait_cyc(2);
        chk("R4 run completes with lane disabled", done_cnt, 3);
        junk3 = 0;

        // ---- timeout ----
        skip_tune = 1'b0; lane_en = '1; tmo_lim = 10'd6;
        pulse_start();
        wait_cyc(15);
        chk("R10 timeout error pulse", err_cnt, 1);
        chk("R10 idle after timeout", busy, 0);

        // ---- no lane enabled ----
        role_up = 1'b1; lane_en = '0; tmo_lim = 10'd20;
        pulse_start();
        wait_cyc(5);
        chk("R4 no lane holds phase0", phase, 0);
        chk("R4 no lane still busy", busy, 1);
        wait_cyc(25);
        chk("R10 timeout with no lanes", err_cnt, 2);
        chk("R4 no completion without lanes", done_cnt, 3);

        wait_cyc(2);
        cmp_en = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule